// File: doc/BRIEF.md
# ADC Sample Trigger Selector

This block decides when an analog-to-digital conversion begins. It watches three possible trigger sources and emits a one-clock start pulse for each event on the source that is currently selected. The three sources are a software strobe from the host, an edge on an asynchronous digital input pin, and a rising edge on the output of a pacer counter. The two asynchronous inputs are brought into the clock domain by a synchronizer chain before their edges are detected. Each source keeps its own edge history, so switching the selection never produces a false start.

A conversion gate sits in front of the start output. While the gate is closed, every trigger is dropped. In compatibility mode, a DMA terminal-count pulse closes the gate. The host reopens it by writing zero to the gate register. A terminal count also raises an interrupt request when the interrupt is enabled, whatever the mode.

Top module: `smp_trig_sel`

## Requirements
- R1: While reset is held and in the cycle after it is released, `conv_start`, `gate_closed` and `tc_irq` are 0.
- R2: With `src_sel` equal to 2'b00 or 2'b01, each clock edge that samples `sw_strobe` high makes `conv_start` high for the following cycle (gate open).
- R3: With `src_sel` equal to 2'b10, a change of `din_raw` first sampled at clock edge k gives one `conv_start` cycle after edge k+2. The change counts only if it matches `din_fall_sel` (0 = rising, 1 = falling).
- R4: With `src_sel` equal to 2'b11, a rising edge of `pacer_raw` first sampled at edge k gives one `conv_start` cycle after edge k+2. Falling edges of `pacer_raw` start nothing.
- R5: Activity on a source that is not selected never produces `conv_start`. Changing `src_sel` while an input is held at a steady level produces no start.
- R6: With `compat_mode` high, `dma_tc` sampled high closes the gate from the next cycle on. No `conv_start` follows any cycle in which `gate_closed` is high.
- R7: With `compat_mode` low, `dma_tc` never changes `gate_closed`.
- R8: A host write (`gate_wr_en`) with data zero opens the gate in the next cycle. A write with non-zero data leaves `gate_closed` unchanged.
- R9: When a compatibility-mode terminal count and a zero write arrive in the same cycle, the gate ends up closed.
- R10: `tc_irq` is high for exactly the cycle after each edge that samples `dma_tc` and `tc_irq_en` both high, in either mode. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Trigger source: 0x software, 10 pin, 11 pacer |
| din_fall_sel | input | 1 | Pin edge polarity: 0 rising, 1 falling |
| sw_strobe | input | 1 | Software trigger strobe, synchronous |
| din_raw | input | 1 | Asynchronous digital input pin |
| pacer_raw | input | 1 | Asynchronous pacer counter output |
| dma_tc | input | 1 | DMA terminal-count pulse, synchronous |
| tc_irq_en | input | 1 | Enables the terminal-count interrupt |
| compat_mode | input | 1 | Strap: terminal count closes the gate |
| gate_wr_en | input | 1 | Host write strobe to the gate register |
| gate_wr_data | input | WR_W | Host write data; zero reopens the gate |
| conv_start | output | 1 | One-cycle conversion start pulse |
| gate_closed | output | 1 | Conversion gate state, 1 = triggers blocked |
| tc_irq | output | 1 | Terminal-count interrupt request pulse |

## Verification
The terminal-count set and the host's zero write can land on the gate register in the same cycle. A trigger can also arrive in the very cycle in which the gate closes. Directed cases drive a terminal count and a zero write in one cycle, and send strobes and pin edges in the cycles around a terminal count. A seeded random phase creates further collisions by giving terminal counts and writes overlapping probabilities. A reference model in the bench, built from the stated priorities (the set wins, and a trigger is blocked only by the gate state of the previous cycle), judges the outputs every cycle.

// File: rtl/smp_trig_pkg.sv
package smp_trig_pkg;

    typedef enum logic [1:0] {
        SRC_SW_A  = 2'b00,
        SRC_SW_B  = 2'b01,
        SRC_PIN   = 2'b10,
        SRC_PACER = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic is_soft(input src_sel_e s);
        return (s == SRC_SW_A) || (s == SRC_SW_B);
    endfunction

endpackage

// File: rtl/smp_edge_sync.sv
module smp_edge_sync
    import smp_trig_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    output edge_t edges
);
    logic [STAGES-1:0] chain;
    logic              hist;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("smp_edge_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            hist  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], raw};
            hist  <= chain[STAGES-1];
        end
    end

    assign edges = edge_of(chain[STAGES-1], hist);
endmodule

// File: rtl/smp_src_mux.sv
module smp_src_mux
    import smp_trig_pkg::*;
(
    input  src_sel_e sel,
    input  logic     pin_fall,
    input  logic     sw,
    input  edge_t    pin_e,
    input  edge_t    pacer_e,
    output logic     fire
);
    always_comb begin
        fire = 1'b0;
        if (is_soft(sel)) begin
            fire = sw;
        end else if (sel == SRC_PIN) begin
            fire = pin_fall ? pin_e.fall : pin_e.rise;
        end else begin
            fire = pacer_e.rise;
        end
    end
endmodule

// File: rtl/smp_gate.sv
module smp_gate #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tc,
    input  logic          compat,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          closed
);
    logic set_req;
    logic clr_req;

    assign set_req = tc & compat;
    assign clr_req = wr_en & (wr_data == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            closed <= 1'b0;
        end else if (set_req) begin
            closed <= 1'b1;
        end else if (clr_req) begin
            closed <= 1'b0;
        end
    end
endmodule

// File: rtl/smp_trig_sel.sv
module smp_trig_sel
    import smp_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WR_W        = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      src_sel,
    input  logic            din_fall_sel,
    input  logic            sw_strobe,
    input  logic            din_raw,
    input  logic            pacer_raw,
    input  logic            dma_tc,
    input  logic            tc_irq_en,
    input  logic            compat_mode,
    input  logic            gate_wr_en,
    input  logic [WR_W-1:0] gate_wr_data,
    output logic            conv_start,
    output logic            gate_closed,
    output logic            tc_irq
);
    edge_t pin_e;
    edge_t pacer_e;
    logic  fire;

    smp_edge_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (din_raw),
        .edges (pin_e)
    );

    smp_edge_sync #(.STAGES(SYNC_STAGES)) u_pacer_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pacer_raw),
        .edges (pacer_e)
    );

    smp_src_mux u_mux (
        .sel      (src_sel_e'(src_sel)),
        .pin_fall (din_fall_sel),
        .sw       (sw_strobe),
        .pin_e    (pin_e),
        .pacer_e  (pacer_e),
        .fire     (fire)
    );

    smp_gate #(.DW(WR_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .tc      (dma_tc),
        .compat  (compat_mode),
        .wr_en   (gate_wr_en),
        .wr_data (gate_wr_data),
        .closed  (gate_closed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            tc_irq     <= 1'b0;
        end else begin
            conv_start <= fire & ~gate_closed;
            tc_irq     <= dma_tc & tc_irq_en;
        end
    end
endmodule

// File: rtl/smp_trig_sel_chk.sv
module smp_trig_sel_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    src_sel,
    input logic          sw_strobe,
    input logic          dma_tc,
    input logic          tc_irq_en,
    input logic          compat_mode,
    input logic          gate_wr_en,
    input logic [DW-1:0] gate_wr_data,
    input logic          conv_start,
    input logic          gate_closed,
    input logic          tc_irq
);
    // R2
    soft_start_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_strobe && !src_sel[1] && !gate_closed) |=> conv_start);

    // R6
    gate_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        gate_closed |=> !conv_start);

    // R6
    tc_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_tc && compat_mode) |=> gate_closed);

    // R7
    gate_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_closed) |-> $past(dma_tc && compat_mode));

    // R8
    gate_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_closed) && !$past(rst)) |-> $past(gate_wr_en && gate_wr_data == '0));

    // R10
    irq_on_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_tc && tc_irq_en) |=> tc_irq);

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(dma_tc && tc_irq_en) |=> !tc_irq);
endmodule

bind smp_trig_sel smp_trig_sel_chk #(.DW(WR_W)) chk_i (.*);

// File: tb/smp_trig_sel_tb_top.sv
module smp_trig_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR_W       = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      src_sel = 2'b00;
    logic            din_fall_sel = 1'b0;
    logic            sw_strobe = 1'b0;
    logic            din_raw = 1'b0;
    logic            pacer_raw = 1'b0;
    logic            dma_tc = 1'b0;
    logic            tc_irq_en = 1'b0;
    logic            compat_mode = 1'b0;
    logic            gate_wr_en = 1'b0;
    logic [WR_W-1:0] gate_wr_data = '0;
    logic            conv_start;
    logic            gate_closed;
    logic            tc_irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_trig_sel #(.SYNC_STAGES(2), .WR_W(WR_W)) dut_i (.*);

    // Reference model: raw level history (index 0 newest), gate, outputs.
    logic [2:0] pin_h = '0;
    logic [2:0] pac_h = '0;
    logic       exp_gate = 1'b0;
    logic       exp_start = 1'b0;
    logic       exp_irq = 1'b0;

    function automatic logic want_start(input logic [1:0] sel, input logic fall,
                                        input logic sw, input logic [2:0] ph,
                                        input logic [2:0] qh, input logic gate);
        logic ev;
        // A level first sampled at edge k is compared with its predecessor at edge k+2.
        if (sel[1] == 1'b0)      ev = sw;
        else if (sel == 2'b10)   ev = fall ? (!ph[1] && ph[2]) : (ph[1] && !ph[2]);
        else                     ev = qh[1] && !qh[2];
        return ev && !gate;
    endfunction

    function automatic logic next_gate(input logic gate, input logic tc, input logic cm,
                                       input logic we, input logic [WR_W-1:0] wd);
        if (tc && cm)              return 1'b1;
        if (we && wd == '0)        return 1'b0;
        return gate;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            pin_h     <= '0;
            pac_h     <= '0;
            exp_gate  <= 1'b0;
            exp_start <= 1'b0;
            exp_irq   <= 1'b0;
        end else begin
            pin_h     <= {pin_h[1:0], din_raw};
            pac_h     <= {pac_h[1:0], pacer_raw};
            exp_start <= want_start(src_sel, din_fall_sel, sw_strobe, pin_h, pac_h, exp_gate);
            exp_gate  <= next_gate(exp_gate, dma_tc, compat_mode, gate_wr_en, gate_wr_data);
            exp_irq   <= dma_tc && tc_irq_en;
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare all outputs at the falling edge.
    task automatic step();
        @(negedge clk);
        check_bit("conv_start", conv_start, exp_start);
        check_bit("gate_closed", gate_closed, exp_gate);
        check_bit("tc_irq", tc_irq, exp_irq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_sw();
        sw_strobe = 1'b1; step(); sw_strobe = 1'b0;
    endtask

    task automatic pulse_tc();
        dma_tc = 1'b1; step(); dma_tc = 1'b0;
    endtask

    task automatic host_write(input logic [WR_W-1:0] d);
        gate_wr_en = 1'b1; gate_wr_data = d; step();
        gate_wr_en = 1'b0; gate_wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2024));

        // R1: reset state, with inputs active during reset
        cur_req = "R1";
        din_raw = 1'b1; sw_strobe = 1'b1; dma_tc = 1'b1; compat_mode = 1'b1; tc_irq_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_bit("conv_start", conv_start, 1'b0);
            check_bit("gate_closed", gate_closed, 1'b0);
            check_bit("tc_irq", tc_irq, 1'b0);
        end
        din_raw = 1'b0; sw_strobe = 1'b0; dma_tc = 1'b0; compat_mode = 1'b0; tc_irq_en = 1'b0;
        rst = 1'b0;
        step();
        check_bit("conv_start after release", conv_start, 1'b0);
        check_bit("gate_closed after release", gate_closed, 1'b0);
        idle(4);

        // R2: software strobes on both soft encodings, back to back
        cur_req = "R2";
        src_sel = 2'b00; pulse_sw(); idle(2);
        src_sel = 2'b01; sw_strobe = 1'b1; step(); step(); sw_strobe = 1'b0; idle(3);

        // R3: pin edges with both polarities
        cur_req = "R3";
        src_sel = 2'b10; din_fall_sel = 1'b0;
        din_raw = 1'b1; idle(6); din_raw = 1'b0; idle(6);
        din_fall_sel = 1'b1;
        din_raw = 1'b1; idle(6); din_raw = 1'b0; idle(6);
        din_raw = 1'b1; step(); din_raw = 1'b0; idle(6);
        din_fall_sel = 1'b0;

        // R4: pacer rising only
        cur_req = "R4";
        src_sel = 2'b11;
        pacer_raw = 1'b1; idle(5); pacer_raw = 1'b0; idle(5);
        pacer_raw = 1'b1; step(); pacer_raw = 1'b0; step(); pacer_raw = 1'b1; idle(5);
        pacer_raw = 1'b0; idle(4);

        // R5: unselected activity and switching with steady levels
        cur_req = "R5";
        src_sel = 2'b00;
        din_raw = 1'b1; pacer_raw = 1'b1; idle(5);
        src_sel = 2'b10; idle(4);
        src_sel = 2'b11; idle(4);
        src_sel = 2'b10; sw_strobe = 1'b1; idle(3); sw_strobe = 1'b0;
        din_raw = 1'b0; pacer_raw = 1'b0; idle(5);

        // R7: terminal count outside compatibility mode
        cur_req = "R7";
        compat_mode = 1'b0; src_sel = 2'b00;
        pulse_tc(); idle(2); pulse_sw(); idle(2);

        // R6: terminal count closes gate; strobe in the closing cycle still fires
        cur_req = "R6";
        compat_mode = 1'b1;
        dma_tc = 1'b1; sw_strobe = 1'b1; step(); dma_tc = 1'b0; sw_strobe = 1'b0; idle(2);
        pulse_sw(); idle(2);
        src_sel = 2'b10; din_raw = 1'b1; idle(5); din_raw = 1'b0;
        src_sel = 2'b11; pacer_raw = 1'b1; idle(5); pacer_raw = 1'b0; idle(3);

        // R8: non-zero write ignored, zero write reopens
        cur_req = "R8";
        src_sel = 2'b00;
        host_write(8'h5A); pulse_sw(); idle(2);
        host_write(8'h01); idle(2);
        host_write(8'h00); pulse_sw(); idle(2);
        host_write(8'h00); idle(2);

        // R9: set and clear in the same cycle
        cur_req = "R9";
        dma_tc = 1'b1; gate_wr_en = 1'b1; gate_wr_data = '0; step();
        dma_tc = 1'b0; gate_wr_en = 1'b0;
        check_bit("gate_closed after collision", gate_closed, 1'b1);
        pulse_sw(); idle(2);
        host_write(8'h00); idle(2);

        // R10: interrupt pulses in both modes
        cur_req = "R10";
        tc_irq_en = 1'b1; compat_mode = 1'b0; pulse_tc(); idle(2);
        compat_mode = 1'b1; pulse_tc(); idle(2);
        tc_irq_en = 1'b0; pulse_tc(); idle(2);
        tc_irq_en = 1'b1; dma_tc = 1'b1; step(); step(); dma_tc = 1'b0; idle(2);
        host_write(8'h00); idle(2);

        // R5 and collisions: constrained random
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) src_sel = 2'($urandom);
            if (($urandom % 60) == 0) din_fall_sel = ~din_fall_sel;
            if (($urandom % 5) == 0)  din_raw = ~din_raw;
            if (($urandom % 4) == 0)  pacer_raw = ~pacer_raw;
            sw_strobe    = (($urandom % 6) == 0);
            dma_tc       = (($urandom % 50) == 0);
            tc_irq_en    = (($urandom % 3) != 0);
            if (($urandom % 200) == 0) compat_mode = ~compat_mode;
            gate_wr_en   = (($urandom % 25) == 0);
            gate_wr_data = (($urandom % 2) == 0) ? '0 : WR_W'($urandom);
            step();
        end
        sw_strobe = 1'b0; dma_tc = 1'b0; gate_wr_en = 1'b0;
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule